// File: doc/BRIEF.md
# Dual-Context Address Translation Buffer

This block maps an 18-bit word address onto a physical word address. It holds two directly indexed tables of 512 page entries: one serves the executive context and one serves the user context. When paging is switched off, a fixed identity mapping is used in their place. Each lookup carries an address, a read/write flag and a flag that selects the current or the previous context. Addresses below 16 never reach a table. They select one of two accumulator blocks.

A lookup whose entry cannot satisfy the access raises a one-cycle refill request and holds `busy` high. An external walker then answers on the fill port, either with a new entry or with a fault. The block stores the returned entry in the table the lookup used and completes the pending lookup. A fault aborts the lookup instead. Software-visible events map onto two control inputs. A base-register reload clears both tables completely. A page invalidate clears a single page in both tables. Any physical address at or above the installed memory size is flagged as nonexistent, and the block returns a fault word with it.

Top module: `xlate_buf`

## Requirements
- R1: The page number is address bits [17:9] and the word offset is bits [8:0]. The physical address is the stored page base ORed with the offset. A lookup that hits is answered with `rsp_vld` on the clock edge that accepts it, so the response is visible in the following cycle.
- R2: Each entry holds, from the top bit down, a writable bit, a valid bit and the 20-bit page base. A read hits when the entry is nonzero. A write hits only when the top (writable) bit is set.
- R3: A lookup that does not hit raises `busy` and a single-cycle `miss_req`. This carries the address, the write flag and the table used (`miss_user`=1 means the user table). `busy` stays high and no response is given until the fill port answers.
- R4: A fill accepted while `busy` stores the entry, valid and with the returned writable bit, at the pending page of the pending table. The pending lookup then completes with an address built from that entry, and later lookups of the page hit.
- R5: A fill that carries a fault completes the lookup with `rsp_abort`=1 and `rsp_pa`=0, and stores nothing. A repeated lookup misses again.
- R6: An address below 16 returns `rsp_ac`=1, `rsp_ac_prev` equal to the previous-context flag, and `rsp_pa` equal to the address. It never misses and never reports nonexistent memory.
- R7: In user mode, both contexts use the user table. In executive mode, the current context uses the executive table. The previous context uses the user table only when `user_io` is 1.
- R8: With paging off, every lookup hits for both read and write, and `rsp_pa` equals the address.
- R9: Reset, and a cycle with `base_load`=1, empty both tables.
- R10: `clr_pg` empties page `clr_vpn` in both tables and leaves other pages intact.
- R11: When the physical address is at or above `MEM_WORDS` (default 131072), `rsp_nxm`=1 and `rsp_fault_word` = {physical flag (bit 21, 1 when paging is off), user-mode flag (bit 20), address (bits 19:0)}. Otherwise the fault word is zero.
- R12: When a fill and a clear of the same page fall in one cycle, the clear wins for the stored entry. The pending lookup still completes with the filled address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties both tables |
| paging_en | input | 1 | 1 = translate through tables, 0 = identity |
| user_mode | input | 1 | 1 = processor runs in user context |
| user_io | input | 1 | Executive mode: steer previous-context lookups to the user table |
| base_load | input | 1 | Base-register reload, empties both tables |
| clr_pg | input | 1 | Empty one page in both tables |
| clr_vpn | input | 9 | Page to empty |
| req_vld | input | 1 | Lookup request, accepted when `busy` is 0 |
| req_va | input | 18 | Word address of the lookup |
| req_wr | input | 1 | 1 = write access |
| req_prev | input | 1 | 1 = previous-context reference |
| busy | output | 1 | Waiting for a fill |
| miss_req | output | 1 | One-cycle refill request |
| miss_va | output | 18 | Address needing refill |
| miss_wr | output | 1 | Refill is for a write |
| miss_user | output | 1 | Refill targets the user table |
| fill_vld | input | 1 | Fill answer valid |
| fill_fault | input | 1 | Fill answer is a fault |
| fill_wr_ok | input | 1 | Filled page is writable |
| fill_ppn | input | 11 | Filled physical page number |
| rsp_vld | output | 1 | Response valid |
| rsp_pa | output | 20 | Physical word address |
| rsp_ac | output | 1 | Response selects an accumulator block |
| rsp_ac_prev | output | 1 | Accumulator block is the previous one |
| rsp_nxm | output | 1 | Address beyond installed memory |
| rsp_abort | output | 1 | Lookup aborted by a fill fault |
| rsp_fault_word | output | 22 | Nonexistent-memory fault word |

## Verification
A fill answer and a page clear can land on the same clock edge for the same page. Table write priority then decides what survives. The bench provokes this by asserting `clr_pg` with the pending page number during the fill cycle. It judges the outcome twice. The response must still carry the filled address, and a second lookup of that page must raise a new refill request instead of hitting.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W   = 18;
  localparam int OFF_W  = 9;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PA_W   = 20;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int N_PG   = 1 << VPN_W;
  localparam int N_TBL  = 2;
  localparam int AC_LIM = 16;
  localparam int FW_W   = PA_W + 2;

  // Writable bit sits at the sign position of the entry.
  typedef struct packed {
    logic            wr_ok;
    logic            vld;
    logic [PA_W-1:0] base;
  } xent_t;

  function automatic logic f_rd_hit(input xent_t e);
    return (e != '0);
  endfunction

  function automatic logic f_wr_hit(input xent_t e);
    return e.wr_ok;
  endfunction

  function automatic logic [PA_W-1:0] f_pa(input xent_t e, input logic [VA_W-1:0] va);
    return e.base | {{(PA_W-OFF_W){1'b0}}, va[OFF_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] f_ac_pa(input logic [VA_W-1:0] va);
    return {{(PA_W-VA_W){1'b0}}, va};
  endfunction

  function automatic xent_t f_ident(input logic [VPN_W-1:0] vpn);
    xent_t e;
    e.wr_ok = 1'b1;
    e.vld   = 1'b1;
    e.base  = {{(PA_W-VA_W){1'b0}}, vpn, {OFF_W{1'b0}}};
    return e;
  endfunction

  function automatic xent_t f_mk_ent(input logic w, input logic [PPN_W-1:0] ppn);
    xent_t e;
    e.wr_ok = w;
    e.vld   = 1'b1;
    e.base  = {ppn, {OFF_W{1'b0}}};
    return e;
  endfunction

  function automatic logic f_beyond(input logic [PA_W-1:0] pa, input logic [31:0] lim);
    return {{(32-PA_W){1'b0}}, pa} >= lim;
  endfunction

  function automatic logic [FW_W-1:0] f_fault_word(input logic phys, input logic usr,
                                                    input logic [PA_W-1:0] pa);
    return {phys, usr, pa};
  endfunction
endpackage

// File: rtl/xlate_route.sv
module xlate_route
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic            prev,
  input  logic            user_mode,
  input  logic            user_io,
  input  logic            paging_en,
  output logic            is_ac,
  output logic            is_phys,
  output logic            tbl_user
);
  localparam int AC_BITS = $clog2(AC_LIM);

  always_comb begin
    is_ac    = (va[VA_W-1:AC_BITS] == '0);
    is_phys  = !paging_en;
    tbl_user = user_mode | (prev & user_io);
  end
endmodule

// File: rtl/xlate_table.sv
module xlate_table
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_pg,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  xent_t            wr_ent,
  input  logic [VPN_W-1:0] rd_vpn,
  output xent_t            rd_ent
);
  xent_t mem [N_PG];

  // Clears take priority over a fill to the same page.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PG; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < N_PG; i++) begin
        if (clr_all || (clr_pg && clr_vpn == VPN_W'(i)))
          mem[i] <= '0;
        else if (wr_en && wr_vpn == VPN_W'(i))
          mem[i] <= wr_ent;
      end
    end
  end

  assign rd_ent = mem[rd_vpn];

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (rd_ent == '0));

  p_clear_pg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pg |=> ((rd_vpn != $past(clr_vpn)) || (rd_ent == '0)));

  p_fill_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all && !(clr_pg && clr_vpn == wr_vpn))
      |=> ((rd_vpn != $past(wr_vpn)) || (rd_ent == $past(wr_ent))));
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter logic [31:0] MEM_WORDS = 32'd131072
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             paging_en,
  input  logic             user_mode,
  input  logic             user_io,
  input  logic             base_load,
  input  logic             clr_pg,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic             req_vld,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_wr,
  input  logic             req_prev,
  output logic             busy,
  output logic             miss_req,
  output logic [VA_W-1:0]  miss_va,
  output logic             miss_wr,
  output logic             miss_user,
  input  logic             fill_vld,
  input  logic             fill_fault,
  input  logic             fill_wr_ok,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             rsp_vld,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_ac,
  output logic             rsp_ac_prev,
  output logic             rsp_nxm,
  output logic             rsp_abort,
  output logic [FW_W-1:0]  rsp_fault_word
);
  logic             busy_q, miss_q, pend_wr, pend_user;
  logic [VA_W-1:0]  pend_va;
  logic             is_ac, is_phys, tbl_user;
  logic [VPN_W-1:0] req_vpn, pend_vpn;
  xent_t            rd_ent [N_TBL];
  xent_t            sel_ent, fill_ent;
  logic             look_hit;
  logic [PA_W-1:0]  look_pa;

  // Named events used by the assertions.
  logic ev_accept, ev_hit, ev_miss, ev_fill;

  logic [PA_W-1:0]  nx_pa;
  logic             nx_ac, nx_acp, nx_abort, nx_phys, nx_nxm;
  logic [FW_W-1:0]  nx_fw;

  assign req_vpn  = req_va[VA_W-1:OFF_W];
  assign pend_vpn = pend_va[VA_W-1:OFF_W];
  assign fill_ent = f_mk_ent(fill_wr_ok, fill_ppn);

  xlate_route u_route (
    .va        (req_va),
    .prev      (req_prev),
    .user_mode (user_mode),
    .user_io   (user_io),
    .paging_en (paging_en),
    .is_ac     (is_ac),
    .is_phys   (is_phys),
    .tbl_user  (tbl_user)
  );

  // Table 0 = executive, table 1 = user.
  for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
    xlate_table u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (base_load),
      .clr_pg  (clr_pg),
      .clr_vpn (clr_vpn),
      .wr_en   (ev_fill && !fill_fault && (pend_user == 1'(g))),
      .wr_vpn  (pend_vpn),
      .wr_ent  (fill_ent),
      .rd_vpn  (req_vpn),
      .rd_ent  (rd_ent[g])
    );
  end

  always_comb begin
    sel_ent  = is_phys ? f_ident(req_vpn) : rd_ent[tbl_user];
    look_hit = is_ac | (req_wr ? f_wr_hit(sel_ent) : f_rd_hit(sel_ent));
    look_pa  = is_ac ? f_ac_pa(req_va) : f_pa(sel_ent, req_va);
  end

  assign ev_accept = req_vld && !busy_q;
  assign ev_hit    = ev_accept && look_hit;
  assign ev_miss   = ev_accept && !look_hit;
  assign ev_fill   = busy_q && fill_vld;

  always_comb begin
    if (ev_fill) begin
      nx_pa    = fill_fault ? '0 : f_pa(fill_ent, pend_va);
      nx_ac    = 1'b0;
      nx_acp   = 1'b0;
      nx_abort = fill_fault;
      nx_phys  = 1'b0;
    end else begin
      nx_pa    = look_pa;
      nx_ac    = is_ac;
      nx_acp   = is_ac & req_prev;
      nx_abort = 1'b0;
      nx_phys  = is_phys;
    end
    nx_nxm = !nx_ac && !nx_abort && f_beyond(nx_pa, MEM_WORDS);
    nx_fw  = nx_nxm ? f_fault_word(nx_phys, user_mode, nx_pa) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q         <= 1'b0;
      miss_q         <= 1'b0;
      pend_va        <= '0;
      pend_wr        <= 1'b0;
      pend_user      <= 1'b0;
      rsp_vld        <= 1'b0;
      rsp_pa         <= '0;
      rsp_ac         <= 1'b0;
      rsp_ac_prev    <= 1'b0;
      rsp_nxm        <= 1'b0;
      rsp_abort      <= 1'b0;
      rsp_fault_word <= '0;
    end else begin
      miss_q  <= 1'b0;
      rsp_vld <= 1'b0;
      if (ev_miss) begin
        busy_q    <= 1'b1;
        miss_q    <= 1'b1;
        pend_va   <= req_va;
        pend_wr   <= req_wr;
        pend_user <= tbl_user;
      end
      if (ev_fill) busy_q <= 1'b0;
      if (ev_hit || ev_fill) begin
        rsp_vld        <= 1'b1;
        rsp_pa         <= nx_pa;
        rsp_ac         <= nx_ac;
        rsp_ac_prev    <= nx_acp;
        rsp_nxm        <= nx_nxm;
        rsp_abort      <= nx_abort;
        rsp_fault_word <= nx_fw;
      end
    end
  end

  assign busy      = busy_q;
  assign miss_req  = miss_q;
  assign miss_va   = pend_va;
  assign miss_wr   = pend_wr;
  assign miss_user = pend_user;

  p_miss_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> busy_q);

  p_no_rsp_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !rsp_vld);

  p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> (!busy_q && rsp_vld));

  p_abort_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_abort) |-> (rsp_pa == '0 && !rsp_nxm));

  p_ac_no_nxm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_ac) |-> !rsp_nxm);

  p_phys_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !paging_en) |=> (rsp_vld && !busy_q));
endmodule

// File: tb/xlate_buf_tb.sv
module xlate_buf_tb;
  localparam logic [31:0] MEMW = 32'd131072;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        paging_en = 1'b1, user_mode = 1'b0, user_io = 1'b0;
  logic        base_load = 1'b0, clr_pg = 1'b0;
  logic [8:0]  clr_vpn = '0;
  logic        req_vld = 1'b0, req_wr = 1'b0, req_prev = 1'b0;
  logic [17:0] req_va = '0;
  logic        busy, miss_req, miss_wr, miss_user;
  logic [17:0] miss_va;
  logic        fill_vld = 1'b0, fill_fault = 1'b0, fill_wr_ok = 1'b0;
  logic [10:0] fill_ppn = '0;
  logic        rsp_vld, rsp_ac, rsp_ac_prev, rsp_nxm, rsp_abort;
  logic [19:0] rsp_pa;
  logic [21:0] rsp_fault_word;

  xlate_buf u_dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [19:0] pa;
    logic        ac, acp, nxm, ab;
    logic [21:0] fw;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  logic        mv [2][512];
  logic        mw [2][512];
  logic [10:0] mp [2][512];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_clear_all();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 512; i++) begin
        mv[t][i] = 1'b0; mw[t][i] = 1'b0; mp[t][i] = '0;
      end
  endtask

  function automatic exp_t mk_exp(input logic [19:0] pa, input logic phys);
    exp_t e;
    e.pa  = pa; e.ac = 1'b0; e.acp = 1'b0; e.ab = 1'b0;
    e.nxm = ({12'b0, pa} >= MEMW);
    e.fw  = e.nxm ? {phys, user_mode, pa} : 22'b0;
    return e;
  endfunction

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1", "unexpected response pa", {12'b0, rsp_pa}, 32'h0);
      end else begin
        exp_t  e;
        string tg;
        e  = q.pop_front();
        tg = tq.pop_front();
        chk(rsp_pa == e.pa, tg, "pa", {12'b0, rsp_pa}, {12'b0, e.pa});
        chk({rsp_ac, rsp_ac_prev, rsp_nxm, rsp_abort} == {e.ac, e.acp, e.nxm, e.ab},
            tg, "flags ac/acp/nxm/abort", {28'b0, rsp_ac, rsp_ac_prev, rsp_nxm, rsp_abort},
            {28'b0, e.ac, e.acp, e.nxm, e.ab});
        chk(rsp_fault_word == e.fw, tg, "fault word", {10'b0, rsp_fault_word}, {10'b0, e.fw});
      end
    end
  end

  // Driver: one lookup; on a predicted miss, answers through the fill port.
  task automatic look(input logic [17:0] va, input logic wr, input logic prev,
                      input logic [10:0] fppn, input logic fwok, input logic ffault,
                      input logic fclr, input string tag);
    int          t;
    logic [8:0]  vpn;
    logic        hitm;
    exp_t        e;
    vpn  = va[17:9];
    t    = (user_mode || (prev && user_io)) ? 1 : 0;
    hitm = 1'b1;
    if (va < 18'd16) begin
      e = '0; e.pa = {2'b0, va}; e.ac = 1'b1; e.acp = prev;
    end else if (!paging_en) begin
      e = mk_exp({2'b0, va}, 1'b1);
    end else begin
      hitm = mv[t][vpn] && (!wr || mw[t][vpn]);
      e    = mk_exp({mp[t][vpn], va[8:0]}, 1'b0);
    end
    req_va = va; req_wr = wr; req_prev = prev;
    if (hitm) begin
      q.push_back(e); tq.push_back(tag);
      req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
      #1;
      chk(q.size() == 0, tag, "hit response missing", 32'(q.size()), 32'h0);
      q.delete(); tq.delete();
    end else begin
      req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
      chk(busy && miss_req, "R3", "busy/miss_req after miss", {30'b0, busy, miss_req}, 32'h3);
      chk(miss_va == va && miss_wr == wr && miss_user == t[0], "R3", "miss va/wr/user",
          {12'b0, miss_user, miss_wr, miss_va}, {12'b0, t[0], wr, va});
      @(negedge clk);
      chk(busy && !miss_req, "R3", "miss_req one pulse, busy held", {30'b0, busy, miss_req}, 32'h2);
      if (ffault) begin
        e = '0; e.ab = 1'b1;
      end else begin
        e = mk_exp({fppn, va[8:0]}, 1'b0);
      end
      q.push_back(e); tq.push_back(tag);
      fill_vld = 1'b1; fill_fault = ffault; fill_wr_ok = fwok; fill_ppn = fppn;
      if (fclr) begin clr_pg = 1'b1; clr_vpn = vpn; end
      @(negedge clk);
      fill_vld = 1'b0; fill_fault = 1'b0; clr_pg = 1'b0;
      #1;
      chk(q.size() == 0 && !busy, tag, "fill completion", {31'b0, busy}, 32'h0);
      q.delete(); tq.delete();
      if (fclr) begin
        mv[0][vpn] = 1'b0; mv[1][vpn] = 1'b0;
      end else if (!ffault) begin
        mv[t][vpn] = 1'b1; mw[t][vpn] = fwok; mp[t][vpn] = fppn;
      end
    end
  endtask

  task automatic page_clear(input logic [8:0] vpn);
    clr_pg = 1'b1; clr_vpn = vpn;
    @(negedge clk);
    clr_pg = 1'b0;
    mv[0][vpn] = 1'b0; mv[1][vpn] = 1'b0;
  endtask

  task automatic table_flush();
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    model_clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !miss_req && !rsp_vld, "R9", "reset state",
        {29'b0, busy, miss_req, rsp_vld}, 32'h0);

    // R3 R4: cold miss then fill; R1 R2: hits afterwards
    look(18'h01234, 1'b0, 1'b0, 11'h005, 1'b1, 1'b0, 1'b0, "R4");
    look(18'h01200, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1");
    look(18'h01300, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");
    // R2: read-only page; read hits, write misses
    look(18'h02811, 1'b0, 1'b0, 11'h007, 1'b0, 1'b0, 1'b0, "R4");
    look(18'h02900, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");
    look(18'h02822, 1'b1, 1'b0, 11'h007, 1'b1, 1'b0, 1'b0, "R2");
    look(18'h02823, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");
    // R5: fault aborts and stores nothing
    look(18'h03000, 1'b0, 1'b0, 11'h008, 1'b1, 1'b1, 1'b0, "R5");
    look(18'h03004, 1'b0, 1'b0, 11'h008, 1'b1, 1'b0, 1'b0, "R5");
    // R6: accumulator bypass, also with paging off below
    look(18'h00005, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R6");
    look(18'h0000F, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R6");
    // R7: context steering
    user_mode = 1'b1;
    look(18'h04010, 1'b1, 1'b0, 11'h030, 1'b1, 1'b0, 1'b0, "R7");
    look(18'h04011, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R7");
    user_mode = 1'b0; user_io = 1'b1;
    look(18'h04020, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R7");
    user_io = 1'b0;
    look(18'h04020, 1'b0, 1'b1, 11'h031, 1'b0, 1'b0, 1'b0, "R7");
    look(18'h04021, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
    // R11: paged nonexistent memory, executive then user
    look(18'h05000, 1'b0, 1'b0, 11'h100, 1'b1, 1'b0, 1'b0, "R11");
    user_mode = 1'b1;
    look(18'h05001, 1'b0, 1'b0, 11'h7FF, 1'b1, 1'b0, 1'b0, "R11");
    user_mode = 1'b0;
    // R8: paging off identity, writes hit
    paging_en = 1'b0;
    look(18'h12345, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8");
    look(18'h3FFFF, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R11");
    look(18'h00003, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R6");
    paging_en = 1'b1;
    // R10: page clear hits both tables, leaves others
    user_mode = 1'b1;
    look(18'h01234, 1'b0, 1'b0, 11'h00A, 1'b1, 1'b0, 1'b0, "R10");
    user_mode = 1'b0;
    page_clear(9'h009);
    look(18'h01234, 1'b0, 1'b0, 11'h006, 1'b1, 1'b0, 1'b0, "R10");
    user_mode = 1'b1;
    look(18'h01235, 1'b0, 1'b0, 11'h00B, 1'b1, 1'b0, 1'b0, "R10");
    user_mode = 1'b0;
    look(18'h02812, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10");
    // R9: base reload empties both tables
    table_flush();
    look(18'h02811, 1'b0, 1'b0, 11'h012, 1'b1, 1'b0, 1'b0, "R9");
    user_mode = 1'b1;
    look(18'h04010, 1'b0, 1'b0, 11'h013, 1'b1, 1'b0, 1'b0, "R9");
    user_mode = 1'b0;
    // R12: fill and clear of the same page in one cycle
    look(18'h06000, 1'b0, 1'b0, 11'h00C, 1'b1, 1'b0, 1'b1, "R12");
    look(18'h06001, 1'b0, 1'b0, 11'h00D, 1'b1, 1'b0, 1'b0, "R12");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule